// File: doc/BRIEF.md
# ECC Error Capture and Check-Bit Injection Registers

This block is the software-visible error log and fault-injection control for a DRAM path that is protected by a single-error-correct, double-error-detect code. The decoder signals each corrected and each uncorrected error with a one-cycle pulse. Each pulse carries the failing address, the 8-bit syndrome and the 64-bit data word. The block keeps the first error of each class in a capture bank of its own. It sets a status bit and holds a level interrupt until software acknowledges it. If a second error of the same class arrives before the acknowledge, the block flags it without overwriting the first capture.

An option register selects the ECC mode. In modes where ECC is absent or disabled, error pulses are ignored. The same register arms a one-shot injection. While the injection is armed, an 8-bit pattern is XORed into the check byte presented by the write datapath. The first write strobe consumes the arming, so exactly one write is corrupted.

Software reaches the block through a plain register port. A write lands on the clock edge where the write enable is high. Reads are combinational from the address.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset, the option register (offset 0x00) reads RST_MODE (default 1) with bit 8 and bits 23:16 zero. The interrupt status word (INT_BASE+0x00, default 0x40) reads 0, and `irq` is low.
- R2: A mode reports errors when its bit 0 is 1, so modes 1 and 3 report. In such a mode, a `ce_evt` pulse while status bit 3 is clear does three things one cycle later. It sets status bit 3. It loads the corrected bank: address at 0x18, syndrome in bits 15:8 of 0x1C with the other bits zero, data bits 31:0 at 0x20 and data bits 63:32 at 0x24.
- R3: While a class's first-error bit is set (bit 3 for corrected, bit 5 for uncorrected), a further error of that class leaves its bank unchanged. It sets that class's double-error bit instead (bit 4 for corrected, bit 6 for uncorrected).
- R4: A `ue_evt` pulse sets status bit 5 and loads the uncorrected bank at 0x08/0x0C/0x10/0x14, using the same layout as R2. It does not touch the corrected bank. Corrected and uncorrected pulses in the same cycle are both captured.
- R5: Writing INT_BASE+0x04 clears every status bit written as 1. Status bits written as 0 are kept.
- R6: `irq` is high exactly while any of status bits 6:3 is set. It falls in the cycle after the last of them is cleared.
- R7: In modes 0 and 2, error pulses change neither the status word nor either bank.
- R8: If an error of a class arrives in the same cycle as an acknowledge of that class's first-error bit, the new error is captured, the first-error bit stays set and the double-error bit is not set.
- R9: A single write of the option register stores the mode in bits 1:0, the arm flag in bit 8 and the pattern in bits 23:16. While the injection is armed, `chk_out` equals `chk_in` XOR pattern. Otherwise `chk_out` equals `chk_in`.
- R10: The first cycle with `wr_strobe` high while the injection is armed applies the pattern and clears bit 8. Later writes pass `chk_in` unchanged. Mode and pattern keep their values in the option readback.
- R11: `ecc_mode` always shows the stored option bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ce_evt | input | 1 | Corrected-error pulse |
| ce_addr | input | ERR_ADDR_W | Corrected-error address |
| ce_synd | input | SYND_W | Corrected-error syndrome |
| ce_data | input | DATA_W | Corrected-error data word |
| ue_evt | input | 1 | Uncorrected-error pulse |
| ue_addr | input | ERR_ADDR_W | Uncorrected-error address |
| ue_synd | input | SYND_W | Uncorrected-error syndrome |
| ue_data | input | DATA_W | Uncorrected-error data word |
| wr_strobe | input | 1 | Datapath write taking place this cycle |
| chk_in | input | CHK_W | Check byte from the encoder |
| chk_out | output | CHK_W | Check byte to memory, possibly corrupted |
| ecc_mode | output | 2 | Current ECC mode |
| irq | output | 1 | Level error interrupt |

## Verification
The properties assume that each error class's fields are valid in the cycle its pulse is high. They also assume that a register write and a datapath write may coincide but that reads have no side effects. The stimulus drives every pulse, strobe and register write for exactly one cycle from the falling edge, and it never leaves an error pulse high across two cycles. In this way, each "second error" in the bench is a distinct event rather than a stretched one. Injection is checked both while armed without a strobe and on the consuming strobe, so the one-shot clearing is observed apart from the XOR itself.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

   localparam int REG_W = 32;
   localparam int NCLS  = 2;
   localparam int CLS_CE = 0;
   localparam int CLS_UE = 1;

   // error-bank byte offsets
   localparam int OFS_OPT     = 'h00;
   localparam int OFS_UE_BANK = 'h08;
   localparam int OFS_CE_BANK = 'h18;
   localparam int BANK_BYTES  = 16;
   localparam int ERR_SPAN    = 'h28;

   // offsets inside the interrupt bank
   localparam int INT_STAT = 'h0;
   localparam int INT_ACK  = 'h4;

   localparam int ST_W = 7;

   // option register fields
   localparam int OPT_ARM_BIT = 8;
   localparam int OPT_PAT_LSB = 16;
   localparam int SYND_LSB    = 8;

   function automatic int first_bit(input int cls);
      return (cls == CLS_CE) ? 3 : 5;
   endfunction

   function automatic int dbl_bit(input int cls);
      return first_bit(cls) + 1;
   endfunction

   function automatic int bank_base(input int cls);
      return (cls == CLS_CE) ? OFS_CE_BANK : OFS_UE_BANK;
   endfunction

   // modes with bit 0 set report errors
   function automatic logic mode_reports(input logic [1:0] m);
      return m[0];
   endfunction

endpackage

// File: rtl/ecc_capture_bank.sv
module ecc_capture_bank #(
   parameter int ERR_ADDR_W = 32,
   parameter int SYND_W     = 8,
   parameter int DATA_W     = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  evt,
   input  logic [ERR_ADDR_W-1:0] evt_addr,
   input  logic [SYND_W-1:0]     evt_synd,
   input  logic [DATA_W-1:0]     evt_data,
   input  logic                  clr_first,
   input  logic                  clr_dbl,
   output logic                  first_q,
   output logic                  dbl_q,
   output logic [ERR_ADDR_W-1:0] cap_addr,
   output logic [SYND_W-1:0]     cap_synd,
   output logic [DATA_W-1:0]     cap_data
);

   logic slot_free;
   assign slot_free = !first_q || clr_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q  <= 1'b0;
         dbl_q    <= 1'b0;
         cap_addr <= '0;
         cap_synd <= '0;
         cap_data <= '0;
      end else begin
         if (evt && slot_free) begin
            first_q  <= 1'b1;
            cap_addr <= evt_addr;
            cap_synd <= evt_synd;
            cap_data <= evt_data;
         end else if (clr_first) begin
            first_q <= 1'b0;
         end
         if (evt && !slot_free)
            dbl_q <= 1'b1;
         else if (clr_dbl)
            dbl_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ecc_inject_unit.sv
module ecc_inject_unit #(
   parameter int CHK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_arm,
   input  logic [CHK_W-1:0] cfg_pat,
   input  logic             wr_strobe,
   input  logic [CHK_W-1:0] chk_in,
   output logic [CHK_W-1:0] chk_out,
   output logic             armed_q,
   output logic [CHK_W-1:0] pat_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         pat_q   <= '0;
      end else if (cfg_we) begin
         armed_q <= cfg_arm;
         pat_q   <= cfg_pat;
      end else if (wr_strobe && armed_q) begin
         armed_q <= 1'b0;
      end
   end

   assign chk_out = armed_q ? (chk_in ^ pat_q) : chk_in;

endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs
   import ecc_regs_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         ERR_ADDR_W = 32,
   parameter int         SYND_W     = 8,
   parameter int         DATA_W     = 64,
   parameter int         CHK_W      = 8,
   parameter int         INT_BASE   = 'h40,
   parameter logic [1:0] RST_MODE   = 2'd1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   input  logic                  ce_evt,
   input  logic [ERR_ADDR_W-1:0] ce_addr,
   input  logic [SYND_W-1:0]     ce_synd,
   input  logic [DATA_W-1:0]     ce_data,
   input  logic                  ue_evt,
   input  logic [ERR_ADDR_W-1:0] ue_addr,
   input  logic [SYND_W-1:0]     ue_synd,
   input  logic [DATA_W-1:0]     ue_data,
   input  logic                  wr_strobe,
   input  logic [CHK_W-1:0]      chk_in,
   output logic [CHK_W-1:0]      chk_out,
   output logic [1:0]            ecc_mode,
   output logic                  irq
);

   localparam int HALF_W = DATA_W / 2;
   localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(OFS_OPT);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(INT_BASE + INT_STAT);
   localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(INT_BASE + INT_ACK);

   // elaboration-time parameter checks
   if (DATA_W != 2 * REG_W) begin : g_bad_data
      $error("DATA_W must be twice the register width");
   end
   if (CHK_W != 8) begin : g_bad_chk
      $error("CHK_W must be 8 to fit option bits 23:16");
   end
   if (SYND_W < 1 || SYND_W > 8) begin : g_bad_synd
      $error("SYND_W must be 1..8");
   end
   if (ERR_ADDR_W < 1 || ERR_ADDR_W > REG_W) begin : g_bad_eaddr
      $error("ERR_ADDR_W must be 1..32");
   end
   if (INT_BASE < ERR_SPAN || (INT_BASE % 8) != 0 || INT_BASE + 8 > (1 << ADDR_W)) begin : g_bad_int
      $error("INT_BASE must be 8-aligned, above the error bank and inside the address space");
   end

   logic [1:0] mode_q;
   logic       opt_we, ack_we, report_en;

   assign opt_we    = reg_we && (reg_addr == A_OPT);
   assign ack_we    = reg_we && (reg_addr == A_ACK);
   assign report_en = mode_reports(mode_q);
   assign ecc_mode  = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= RST_MODE;
      else if (opt_we)
         mode_q <= reg_wdata[1:0];
   end

   // per-class inputs gathered into arrays
   logic [NCLS-1:0]       evt_v;
   logic [ERR_ADDR_W-1:0] in_addr_v  [NCLS];
   logic [SYND_W-1:0]     in_synd_v  [NCLS];
   logic [DATA_W-1:0]     in_data_v  [NCLS];
   logic [NCLS-1:0]       first_v, dbl_v;
   logic [ERR_ADDR_W-1:0] cap_addr_v [NCLS];
   logic [SYND_W-1:0]     cap_synd_v [NCLS];
   logic [DATA_W-1:0]     cap_data_v [NCLS];

   assign evt_v[CLS_CE]     = ce_evt && report_en;
   assign evt_v[CLS_UE]     = ue_evt && report_en;
   assign in_addr_v[CLS_CE] = ce_addr;
   assign in_addr_v[CLS_UE] = ue_addr;
   assign in_synd_v[CLS_CE] = ce_synd;
   assign in_synd_v[CLS_UE] = ue_synd;
   assign in_data_v[CLS_CE] = ce_data;
   assign in_data_v[CLS_UE] = ue_data;

   logic [ST_W-1:0] status;

   for (genvar c = 0; c < NCLS; c++) begin : g_bank
      ecc_capture_bank #(
         .ERR_ADDR_W(ERR_ADDR_W),
         .SYND_W    (SYND_W),
         .DATA_W    (DATA_W)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt_v[c]),
         .evt_addr (in_addr_v[c]),
         .evt_synd (in_synd_v[c]),
         .evt_data (in_data_v[c]),
         .clr_first(ack_we && reg_wdata[first_bit(c)]),
         .clr_dbl  (ack_we && reg_wdata[dbl_bit(c)]),
         .first_q  (first_v[c]),
         .dbl_q    (dbl_v[c]),
         .cap_addr (cap_addr_v[c]),
         .cap_synd (cap_synd_v[c]),
         .cap_data (cap_data_v[c])
      );
   end

   always_comb begin
      status = '0;
      for (int c = 0; c < NCLS; c++) begin
         status[first_bit(c)] = first_v[c];
         status[dbl_bit(c)]   = dbl_v[c];
      end
   end

   assign irq = |status;

   logic             inj_armed;
   logic [CHK_W-1:0] inj_pat;

   ecc_inject_unit #(.CHK_W(CHK_W)) u_inject (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (opt_we),
      .cfg_arm  (reg_wdata[OPT_ARM_BIT]),
      .cfg_pat  (reg_wdata[OPT_PAT_LSB +: CHK_W]),
      .wr_strobe(wr_strobe),
      .chk_in   (chk_in),
      .chk_out  (chk_out),
      .armed_q  (inj_armed),
      .pat_q    (inj_pat)
   );

   // write-data bits that no register field takes
   logic unused_wdata;
   assign unused_wdata = ^{reg_wdata[31:24], reg_wdata[15:9], reg_wdata[7], reg_wdata[2]};

   // read mux
   logic [ADDR_W-1:0] off;
   always_comb begin
      reg_rdata = '0;
      off       = '0;
      if (reg_addr == A_OPT) begin
         reg_rdata[1:0]                     = mode_q;
         reg_rdata[OPT_ARM_BIT]             = inj_armed;
         reg_rdata[OPT_PAT_LSB +: CHK_W]    = inj_pat;
      end else if (reg_addr == A_STAT) begin
         reg_rdata[ST_W-1:0] = status;
      end else begin
         for (int c = 0; c < NCLS; c++) begin
            off = reg_addr - ADDR_W'(bank_base(c));
            if (off < ADDR_W'(BANK_BYTES) && off[1:0] == 2'b00) begin
               case (off[3:2])
                  2'd0:    reg_rdata[ERR_ADDR_W-1:0]      = cap_addr_v[c];
                  2'd1:    reg_rdata[SYND_LSB +: SYND_W]  = cap_synd_v[c];
                  2'd2:    reg_rdata[HALF_W-1:0]          = cap_data_v[c][HALF_W-1:0];
                  default: reg_rdata[HALF_W-1:0]          = cap_data_v[c][DATA_W-1:HALF_W];
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/ecc_err_regs_chk.sv
module ecc_err_regs_chk #(
   parameter int ERR_ADDR_W = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [1:0]            mode,
   input logic                  ce_evt,
   input logic                  ue_evt,
   input logic [ERR_ADDR_W-1:0] ce_addr,
   input logic                  ack_we,
   input logic [6:0]            ack_bits,
   input logic [6:0]            st,
   input logic [ERR_ADDR_W-1:0] ce_cap_addr,
   input logic                  armed,
   input logic                  wr_strobe,
   input logic                  opt_we,
   input logic                  irq
);

   // R2
   ce_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt && mode[0] && !st[3]) |=> (st[3] && ce_cap_addr == $past(ce_addr)));

   // R3
   ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st[3] && !(ack_we && ack_bits[3])) |=> $stable(ce_cap_addr));

   // R3
   ce_dbl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st[4]) |-> $past(st[3]));

   // R3
   ue_dbl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st[6]) |-> $past(st[5]));

   // R7
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[0] && !st[3] && !st[5]) |=> (!st[3] && !st[5]));

   // R8
   ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_evt && mode[0] && ack_we && ack_bits[3]) |=> st[3]);

   // R10
   inject_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && wr_strobe && !opt_we) |=> !armed);

   // R6
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ack_bits[6:3] == 4'hF && !ce_evt && !ue_evt) |=> !irq);

endmodule

bind ecc_err_regs ecc_err_regs_chk #(.ERR_ADDR_W(ERR_ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode_q),
   .ce_evt     (ce_evt),
   .ue_evt     (ue_evt),
   .ce_addr    (ce_addr),
   .ack_we     (ack_we),
   .ack_bits   (reg_wdata[6:0]),
   .st         (status),
   .ce_cap_addr(cap_addr_v[0]),
   .armed      (inj_armed),
   .wr_strobe  (wr_strobe),
   .opt_we     (opt_we),
   .irq        (irq)
);

// File: tb/tb_ecc_err_regs.sv
`timescale 1ns/100ps
module tb_ecc_err_regs;

   localparam logic [7:0] INTB = 8'h40;
   localparam logic [7:0] ACK  = 8'h44;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ce_evt = 1'b0, ue_evt = 1'b0;
   logic [31:0] ce_addr = '0, ue_addr = '0;
   logic [7:0]  ce_synd = '0, ue_synd = '0;
   logic [63:0] ce_data = '0, ue_data = '0;
   logic        wr_strobe = 1'b0;
   logic [7:0]  chk_in = '0;
   logic [7:0]  chk_out;
   logic [1:0]  ecc_mode;
   logic        irq;

   always #2 clk = ~clk;

   ecc_err_regs dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ce_evt(ce_evt), .ce_addr(ce_addr), .ce_synd(ce_synd), .ce_data(ce_data),
      .ue_evt(ue_evt), .ue_addr(ue_addr), .ue_synd(ue_synd), .ue_data(ue_data),
      .wr_strobe(wr_strobe), .chk_in(chk_in), .chk_out(chk_out),
      .ecc_mode(ecc_mode), .irq(irq)
   );

   // scoreboard: 0 = reg_rdata, 1 = irq, 2 = chk_out, 3 = ecc_mode
   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sbq[$];
   event  smp_ev;
   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;

   initial begin
      forever begin
         @(smp_ev);
         while (sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            case (it.kind)
               0:       act = reg_rdata;
               1:       act = {31'b0, irq};
               2:       act = {24'b0, chk_out};
               default: act = {30'b0, ecc_mode};
            endcase
            checks++;
            if (act !== it.exp) begin
               failures++;
               $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_now(input int kind, input logic [7:0] addr,
                             input logic [31:0] exp, input string tag);
      item_t it;
      reg_addr = addr;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      #0.2 -> smp_ev;
      #0.2;
   endtask

   task automatic expect_val(input int kind, input logic [7:0] addr,
                             input logic [31:0] exp, input string tag);
      @(negedge clk);
      expect_now(kind, addr, exp, tag);
   endtask

   task automatic reg_write(input logic [7:0] addr, input logic [31:0] data);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic pulse(input bit ce, input bit ue, input logic [31:0] a,
                        input logic [7:0] s, input logic [63:0] d);
      @(negedge clk);
      ce_evt = ce; ue_evt = ue;
      ce_addr = a; ce_synd = s; ce_data = d;
      ue_addr = a ^ 32'h00F0_0000; ue_synd = ~s; ue_data = ~d;
      @(negedge clk);
      ce_evt = 1'b0; ue_evt = 1'b0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R11 mode output
      expect_val(0, 8'h00, 32'h1, "R1 option");
      expect_val(0, INTB, 32'h0, "R1 status");
      expect_val(1, 8'h00, 32'h0, "R1 irq");
      expect_val(3, 8'h00, 32'h1, "R11 ecc_mode");
      chk_in = 8'h3E;
      expect_val(2, 8'h00, 32'h3E, "R9 passthrough unarmed");

      // R2 corrected capture
      pulse(1, 0, 32'h1234_5670, 8'hA5, 64'hDEAD_BEEF_0123_4567);
      expect_val(0, INTB,  32'h08, "R2 status");
      expect_val(0, 8'h18, 32'h1234_5670, "R2 addr");
      expect_val(0, 8'h1C, 32'h0000_A500, "R2 syndrome");
      expect_val(0, 8'h20, 32'h0123_4567, "R2 data lo");
      expect_val(0, 8'h24, 32'hDEAD_BEEF, "R2 data hi");
      expect_val(1, 8'h00, 32'h1, "R6 irq set");

      // R3 second corrected error
      pulse(1, 0, 32'h0BAD_0000, 8'h3C, 64'h1);
      expect_val(0, INTB,  32'h18, "R3 dbl ce status");
      expect_val(0, 8'h18, 32'h1234_5670, "R3 addr held");
      expect_val(0, 8'h1C, 32'h0000_A500, "R3 synd held");

      // R4 uncorrected bank (ue addr = a^0x00F00000, synd = ~s, data = ~d)
      pulse(0, 1, 32'h0000_8000, 8'hEE, 64'hAAAA_5555_0F0F_F0F0);
      expect_val(0, INTB,  32'h38, "R4 status");
      expect_val(0, 8'h08, 32'h00F0_8000, "R4 ue addr");
      expect_val(0, 8'h0C, 32'h0000_1100, "R4 ue synd");
      expect_val(0, 8'h10, 32'hF0F0_0F0F, "R4 ue data lo");
      expect_val(0, 8'h14, 32'h5555_AAAA, "R4 ue data hi");
      expect_val(0, 8'h18, 32'h1234_5670, "R4 ce bank untouched");

      // R5 selective acknowledge, R6 interrupt
      reg_write(ACK, 32'h08);
      expect_val(0, INTB, 32'h30, "R5 partial ack");
      expect_val(1, 8'h00, 32'h1, "R6 irq held");
      reg_write(ACK, 32'h70);
      expect_val(0, INTB, 32'h00, "R5 full ack");
      expect_val(1, 8'h00, 32'h0, "R6 irq dropped");

      // R4 simultaneous classes, R3 second uncorrected
      pulse(1, 1, 32'h2222_0000, 8'h01, 64'h5);
      expect_val(0, INTB,  32'h28, "R4 both status");
      expect_val(0, 8'h18, 32'h2222_0000, "R4 both ce addr");
      expect_val(0, 8'h08, 32'h22D2_0000, "R4 both ue addr");
      pulse(0, 1, 32'h3333_0000, 8'h02, 64'h6);
      expect_val(0, INTB,  32'h68, "R3 dbl ue status");
      expect_val(0, 8'h08, 32'h22D2_0000, "R3 ue addr held");
      reg_write(ACK, 32'h68);
      expect_val(0, INTB, 32'h00, "R5 ack clear");

      // R8 error together with acknowledge
      pulse(1, 0, 32'h4444_0000, 8'h10, 64'h7);
      @(negedge clk);
      ce_evt = 1'b1; ce_addr = 32'h5555_0000; ce_synd = 8'h20; ce_data = 64'h8;
      reg_we = 1'b1; reg_addr = ACK; reg_wdata = 32'h08;
      @(negedge clk);
      ce_evt = 1'b0; reg_we = 1'b0;
      expect_val(0, INTB,  32'h08, "R8 status stays");
      expect_val(0, 8'h18, 32'h5555_0000, "R8 new addr");
      reg_write(ACK, 32'h08);

      // R7 disabled modes, R11 mode output
      reg_write(8'h00, 32'h2);
      expect_val(3, 8'h00, 32'h2, "R11 ecc_mode 2");
      pulse(1, 1, 32'h6666_0000, 8'h30, 64'h9);
      expect_val(0, INTB,  32'h00, "R7 mode2 status");
      expect_val(0, 8'h18, 32'h5555_0000, "R7 mode2 bank");
      expect_val(1, 8'h00, 32'h0, "R7 mode2 irq");
      reg_write(8'h00, 32'h0);
      pulse(1, 1, 32'h7777_0000, 8'h40, 64'hA);
      expect_val(0, INTB,  32'h00, "R7 mode0 status");
      expect_val(0, 8'h08, 32'h22D2_0000, "R7 mode0 ue bank");
      reg_write(8'h00, 32'h3);
      pulse(1, 0, 32'h8888_0000, 8'h50, 64'hB);
      expect_val(0, INTB,  32'h08, "R2 mode3 reports");
      expect_val(0, 8'h18, 32'h8888_0000, "R2 mode3 addr");
      reg_write(ACK, 32'h08);

      // R9 arm injection, R10 one shot
      reg_write(8'h00, 32'h00C3_0103);
      expect_val(0, 8'h00, 32'h00C3_0103, "R9 option readback");
      chk_in = 8'h5A;
      expect_val(2, 8'h00, 32'h99, "R9 armed xor");
      @(negedge clk);
      wr_strobe = 1'b1; chk_in = 8'h0F;
      expect_now(2, 8'h00, 32'hCC, "R9 xor on write");
      @(negedge clk);
      wr_strobe = 1'b0;
      expect_now(0, 8'h00, 32'h00C3_0003, "R10 arm cleared");
      expect_val(2, 8'h00, 32'h0F, "R10 passthrough after");
      @(negedge clk);
      wr_strobe = 1'b1;
      expect_now(2, 8'h00, 32'h0F, "R10 second write clean");
      @(negedge clk);
      wr_strobe = 1'b0;
      expect_val(3, 8'h00, 32'h3, "R11 ecc_mode 3");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule